// File: doc/BRIEF.md
# Load and Store Byte-Lane Aligner

This block sits between a 32-bit core and a byte-addressed data memory that is one word wide. The core computes the address as base register plus displacement. It then hands the aligner the low address bits, an access size and, for loads, a signedness flag. The aligner turns these into what the memory port and the register file need.

On the store side it copies the register value across every byte lane and builds a byte-enable mask. The memory then writes only the addressed bytes. On the load side it picks the addressed byte or halfword out of the fetched memory word and widens it to 32 bits with sign or zero fill. Halfword and word accesses that do not sit on their natural boundary raise a misaligned flag. With that flag set, no byte is enabled and the load result is forced to zero. Both paths are purely combinational, so results are valid in the same cycle as their inputs.

Top module: `lsu_lane_align`

## Requirements
- R1: With size code 00 (byte), `st_wdata_o` holds the low byte of `st_data_i` in all four lanes. `st_be_o` is 0001 shifted left by `addr_lo_i`. Lane k is bits 8k+7..8k (little-endian).
- R2: With size code 01 (halfword) and `addr_lo_i[0]`=0, `st_wdata_o` holds the low halfword of `st_data_i` in both halves. `st_be_o` is 0011 when `addr_lo_i[1]`=0 and 1100 when it is 1.
- R3: With size code 10 (word) and `addr_lo_i`=00, `st_wdata_o` equals `st_data_i` and `st_be_o` is 1111.
- R4: A byte load with `unsigned_i`=0 returns lane `addr_lo_i` of `ld_word_i`, with its bit 7 copied into bits 31..8.
- R5: A byte load with `unsigned_i`=1 returns the same lane with bits 31..8 cleared.
- R6: An aligned halfword load returns bits 16h+15..16h of `ld_word_i`, where h is `addr_lo_i[1]`. Bits 31..16 are filled with bit 15 of that halfword when `unsigned_i`=0, and with zero when it is 1.
- R7: An aligned word load returns `ld_word_i` unchanged whatever the value of `unsigned_i`.
- R8: A halfword access with `addr_lo_i[0]`=1, or a word access with `addr_lo_i`≠00, drives `misalign_o`=1, `st_be_o`=0000 and `ld_data_o`=0. Every other access drives `misalign_o`=0.
- R9: Size code 11 behaves exactly as size code 10 (word) on every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| st_data_i | input | 32 | Register value to be stored |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| unsigned_i | input | 1 | 1 selects zero fill for loads, 0 sign fill |
| addr_lo_i | input | 2 | Low two bits of the effective address |
| ld_word_i | input | 32 | Word read from memory |
| st_wdata_o | output | 32 | Lane-replicated store data |
| st_be_o | output | 4 | Store byte enables, bit k for lane k |
| ld_data_o | output | 32 | Extracted and extended load result |
| misalign_o | output | 1 | Access is not naturally aligned |

## Verification
The bench builds the block with its default 32-bit data width, which gives four byte lanes and two halfword lanes. At that width every combination of size code, address offset and signedness flag can be applied against several data patterns. The patterns include words whose lane tops alternate between set and clear, so a wrong lane choice or wrong fill bit changes the result. The reserved size code and every misaligned offset are part of the same sweep.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int DW = 32
) (
  input  logic [DW-1:0]         st_data_i,
  input  logic [1:0]            size_i,
  input  logic                  unsigned_i,
  input  logic [$clog2(DW/8)-1:0] addr_lo_i,
  input  logic [DW-1:0]         ld_word_i,
  output logic [DW-1:0]         st_wdata_o,
  output logic [DW/8-1:0]       st_be_o,
  output logic [DW-1:0]         ld_data_o,
  output logic                  misalign_o
);
  localparam int NB = DW / 8;
  localparam int AW = $clog2(NB);

  logic is_byte, is_half, is_word;
  logic [AW-1:0] half_base;
  logic [DW-1:0] byte_shift, half_shift;
  logic [7:0]    lane_b;
  logic [15:0]   lane_h;
  logic [NB-1:0] be_raw;
  logic [DW-1:0] ld_raw;

  assign is_byte = (size_i == 2'b00);
  assign is_half = (size_i == 2'b01);
  assign is_word = size_i[1];

  assign half_base  = {addr_lo_i[AW-1:1], 1'b0};
  assign misalign_o = (is_half & addr_lo_i[0]) | (is_word & (addr_lo_i != '0));

  assign byte_shift = ld_word_i >> {addr_lo_i, 3'b000};
  assign half_shift = ld_word_i >> {half_base, 3'b000};
  assign lane_b     = byte_shift[7:0];
  assign lane_h     = half_shift[15:0];

  always_comb begin
    if (is_byte) begin
      st_wdata_o = {NB{st_data_i[7:0]}};
      be_raw     = {{(NB-1){1'b0}}, 1'b1} << addr_lo_i;
      ld_raw     = {{(DW-8){~unsigned_i & lane_b[7]}}, lane_b};
    end else if (is_half) begin
      st_wdata_o = {(NB/2){st_data_i[15:0]}};
      be_raw     = {{(NB-2){1'b0}}, 2'b11} << half_base;
      ld_raw     = {{(DW-16){~unsigned_i & lane_h[15]}}, lane_h};
    end else begin
      st_wdata_o = st_data_i;
      be_raw     = '1;
      ld_raw     = ld_word_i;
    end
  end

  assign st_be_o   = misalign_o ? '0 : be_raw;
  assign ld_data_o = misalign_o ? '0 : ld_raw;
endmodule

module lsu_lane_align_chk (
  input logic [1:0]  size_i,
  input logic        unsigned_i,
  input logic [1:0]  addr_lo_i,
  input logic [3:0]  st_be_o,
  input logic [31:0] ld_data_o,
  input logic        misalign_o
);
  always_comb begin
    if (!$isunknown({size_i, unsigned_i, addr_lo_i})) begin
      // R8
      be_off_when_misaligned_chk: assert (!misalign_o || (st_be_o == 4'b0000 && ld_data_o == '0));
      // R8
      misalign_rule_chk: assert (misalign_o == ((size_i == 2'b01 && addr_lo_i[0]) || (size_i[1] && addr_lo_i != 2'b00)));
      // R1
      byte_one_lane_chk: assert (size_i != 2'b00 || $countones(st_be_o) == 1);
      // R2
      half_two_lanes_chk: assert (size_i != 2'b01 || misalign_o || $countones(st_be_o) == 2);
      // R3
      word_all_lanes_chk: assert (!size_i[1] || misalign_o || st_be_o == 4'b1111);
      // R5
      ubyte_zero_fill_chk: assert (!(size_i == 2'b00 && unsigned_i) || ld_data_o[31:8] == '0);
    end
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .size_i(size_i), .unsigned_i(unsigned_i), .addr_lo_i(addr_lo_i),
  .st_be_o(st_be_o), .ld_data_o(ld_data_o), .misalign_o(misalign_o)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] st_data, ld_word, wdata, ldd;
  logic [1:0]  size, addr;
  logic        uns, mis;
  logic [3:0]  be;
  logic        run = 1'b0;
  int checks = 0, errors = 0, cyc = 0;

  lsu_lane_align u_dut (
    .st_data_i(st_data), .size_i(size), .unsigned_i(uns), .addr_lo_i(addr),
    .ld_word_i(ld_word), .st_wdata_o(wdata), .st_be_o(be),
    .ld_data_o(ldd), .misalign_o(mis)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h (size=%0d addr=%0d u=%0b)", tag, what, got, exp, size, addr, uns);
    end
  endtask

  task automatic compare();
    int k, off;
    logic [31:0] ew, ed;
    logic [3:0] ebe;
    logic emis;
    logic [7:0] b;
    logic [15:0] h;
    string stag, ltag;
    k = (size == 2'd3) ? 2 : int'(size);
    off = int'(addr);
    emis = (k == 1 && addr[0]) || (k == 2 && addr != 0);
    b = ld_word[8*off +: 8];
    h = ld_word[16*(off/2) +: 16];
    case (k)
      0: begin
        ew = {4{st_data[7:0]}}; ebe = 4'b0001 << off;
        ed = uns ? {24'd0, b} : {{24{b[7]}}, b};
        stag = "R1"; ltag = uns ? "R5" : "R4";
      end
      1: begin
        ew = {2{st_data[15:0]}}; ebe = addr[1] ? 4'b1100 : 4'b0011;
        ed = uns ? {16'd0, h} : {{16{h[15]}}, h};
        stag = "R2"; ltag = "R6";
      end
      default: begin
        ew = st_data; ebe = 4'b1111; ed = ld_word;
        stag = (size == 2'd3) ? "R9" : "R3"; ltag = (size == 2'd3) ? "R9" : "R7";
      end
    endcase
    if (emis) begin
      ebe = 4'b0000; ed = 32'd0; stag = "R8"; ltag = "R8";
    end
    chk(emis ? "R8" : stag, "misalign", {31'd0, mis}, {31'd0, emis});
    chk(stag, "byte enables", {28'd0, be}, {28'd0, ebe});
    chk(stag, "store data", wdata, ew);
    chk(ltag, "load data", ldd, ed);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (run) compare();
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R1 watchdog: got %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h80FF7F01;
    pats[1] = 32'h017F80FE;
    pats[2] = 32'h8000_7FFF;
    pats[3] = 32'h7FFF_8000;
    pats[4] = 32'hDEADBEEF;
    pats[5] = 32'h12345678;
    st_data = '0; ld_word = '0; size = '0; addr = '0; uns = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset-state check, byte store at offset 0 of zero data (R1)
    chk("R1", "reset enables", {28'd0, be}, 32'h1);
    chk("R1", "reset data", wdata, 32'd0);
    run = 1'b1;
    for (int p = 0; p < 6; p++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 4; a++)
          for (int u = 0; u < 2; u++) begin
            @(negedge clk);
            st_data = pats[p];
            ld_word = pats[(p + 1) % 6];
            size = s[1:0]; addr = a[1:0]; uns = u[0];
          end
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      st_data = $urandom; ld_word = $urandom;
      size = 2'($urandom); addr = 2'($urandom); uns = 1'($urandom);
    end
    @(negedge clk);
    run = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule